// File: doc/BRIEF.md
# Debug Status Register with Reset-Cause Capture

This block is the status register of a processor debug unit. It keeps a sticky record of debug events, one bit per event kind, and a two-bit field naming the kind of the most recent reset. Event inputs are single-cycle pulses from the event detection logic. A separate flag notes that an event arrived while the debug-enable state was off, which marks the matching interrupt as imprecise. Three reset-request pulses (core, chip, system) wipe the event bits. Each also loads its own code into the cause field, so the field reports a reset after that reset has happened.

Software never writes data into the register. A write carries a mask: every 1 clears the matching bit and every 0 leaves it alone. The read port is combinational from the stored word, so a read in the cycle of an update returns the value from before that update. Bits are numbered from the most significant end: bit n of the word is data line 31-n.

The cause field is a four-state machine: NONE (code 00), CORE (01), CHIP (10), SYS (11). Each cycle takes exactly one transition. LOAD_SYS, LOAD_CHIP and LOAD_CORE fire on the matching reset request, with system above chip above core. CLEAR fires on a write whose mask covers a field bit and moves to the state whose code is the old code with the masked bits removed. HOLD applies otherwise. The power-on reset puts the machine in NONE.

Top module: `dbg_status_reg`

## Requirements
- R1: After power-on reset (rst_n low) the read word is 0x0000_0000.
- R2: An event status bit, once set, stays set until a mask write or a reset request clears it.
- R3: A write with wr_en clears every bit whose mask bit is 1 and leaves every bit whose mask bit is 0 unchanged.
- R4: When an event pulse and a mask write hit the same bit in the same cycle, the bit ends up set.
- R5: ev_pulse[0] (unconditional event) sets bit 1 (data line 30), ev_pulse[1] (instruction completion) sets bit 4 (line 27), and ev_pulse[2] (branch taken) sets bit 5 (line 26).
- R6: Bit 0 (line 31, imprecise) is set when any event pulse arrives while dbg_en is 0. An event pulse with dbg_en at 1 leaves it unchanged.
- R7: The cause field is bits 2:3 (lines 29:28, bit 2 most significant). A core request loads 01, a chip request loads 10 and a system request loads 11. When several requests arrive in one cycle, system wins over chip and chip wins over core.
- R8: A reset request clears bits 0, 1, 4 and 5 in the next cycle. Event pulses in that cycle are ignored.
- R9: The cause field is changed only by reset requests and by mask writes, bit by bit. Events and other writes leave it unchanged.
- R10: Reserved bits (6 to 31, lines 25:0) always read 0, and mask bits aimed at them have no effect.
- R11: rd_data in any cycle equals the register value before that cycle's update.
- R12: A reset request in the same cycle as a mask write that covers the cause field leaves the requested code in the field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous power-on reset, active low |
| dbg_en | input | 1 | Debug-enable state of the processor |
| ev_pulse | input | 3 | Event pulses: [0] unconditional, [1] instruction completion, [2] branch taken |
| rst_core_req | input | 1 | Core reset occurred (one-cycle pulse) |
| rst_chip_req | input | 1 | Chip reset occurred (one-cycle pulse) |
| rst_sys_req | input | 1 | System reset occurred (one-cycle pulse) |
| wr_en | input | 1 | Software write strobe |
| wr_mask | input | 32 | Write-one-to-clear mask |
| rd_data | output | 32 | Current register value |

## Verification
Two pairs of functions can fall in one cycle: an event setting a bit while a mask write clears it, and a reset request loading the cause field while a mask write clears that field. The bench drives both inputs of each pair in a single cycle. It expects the set to win in the first pair and the loaded code to win in the second, and compares the word read one cycle later. It also drives simultaneous reset requests to check their priority, and drives an event together with a reset request to confirm the event is dropped.

// File: rtl/dstat_pkg.sv
package dstat_pkg;

    localparam int WORD_W = 32;
    localparam int NUM_EV = 3;
    localparam int NUM_STICKY = NUM_EV + 1;

    // Big-endian bit numbers
    localparam int IMP_BIT   = 0;
    localparam int CAUSE_HI  = 2;
    localparam int CAUSE_LO  = 3;
    localparam int UNC_BIT   = 1;
    localparam int ICMP_BIT  = 4;
    localparam int BRT_BIT   = 5;
    localparam int LAST_USED = 5;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_CORE = 2'b01,
        CAUSE_CHIP = 2'b10,
        CAUSE_SYS  = 2'b11
    } cause_e;

    typedef enum logic [2:0] {
        T_HOLD,
        T_CLEAR,
        T_LOAD_CORE,
        T_LOAD_CHIP,
        T_LOAD_SYS
    } cause_trans_e;

    // Big-endian bit number to data line index
    function automatic int line_of(input int bitnum);
        return WORD_W - 1 - bitnum;
    endfunction

    // Sticky slot k: slot 0 is the imprecise flag, slot k+1 is event k
    function automatic int sticky_bit(input int slot);
        case (slot)
            0:       return IMP_BIT;
            1:       return UNC_BIT;
            2:       return ICMP_BIT;
            default: return BRT_BIT;
        endcase
    endfunction

endpackage

// File: rtl/dstat_sticky.sv
module dstat_sticky #(
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wipe,
    input  logic [NB-1:0] set,
    input  logic [NB-1:0] clr,
    output logic [NB-1:0] q
);

    for (genvar k = 0; k < NB; k++) begin : g_bit
        logic nxt;

        always_comb begin
            if (wipe)
                nxt = 1'b0;
            else
                nxt = set[k] | (q[k] & ~clr[k]);
        end

        always_ff @(posedge clk) begin
            if (!rst_n)
                q[k] <= 1'b0;
            else
                q[k] <= nxt;
        end

        // R2: a set bit stays set without clear or wipe
        a_r2_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (q[k] && !clr[k] && !wipe) |=> q[k]);

        // R4: a set in the same cycle as a clear leaves the bit set
        a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (set[k] && clr[k] && !wipe) |=> q[k]);

        // R3: clear without set empties the bit
        a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[k] && !set[k] && !wipe) |=> !q[k]);

        // R8: wipe drops the bit even when a set is present
        a_r8_wipe: assert property (@(posedge clk) disable iff (!rst_n)
            wipe |=> !q[k]);
    end

endmodule

// File: rtl/dstat_cause_fsm.sv
module dstat_cause_fsm
    import dstat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_core,
    input  logic       req_chip,
    input  logic       req_sys,
    input  logic [1:0] clr,
    output cause_e     code
);

    cause_e       state;
    cause_e       nxt;
    cause_trans_e trans;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= CAUSE_NONE;
        else
            state <= nxt;
    end

    always_comb begin
        if (req_sys)
            trans = T_LOAD_SYS;
        else if (req_chip)
            trans = T_LOAD_CHIP;
        else if (req_core)
            trans = T_LOAD_CORE;
        else if (|clr)
            trans = T_CLEAR;
        else
            trans = T_HOLD;

        unique case (trans)
            T_LOAD_SYS:  nxt = CAUSE_SYS;
            T_LOAD_CHIP: nxt = CAUSE_CHIP;
            T_LOAD_CORE: nxt = CAUSE_CORE;
            T_CLEAR:     nxt = cause_e'(state & ~clr);
            T_HOLD:      nxt = state;
            default:     nxt = state;
        endcase
    end

    assign code = state;

    // R7: system request wins
    a_r7_sys_first: assert property (@(posedge clk) disable iff (!rst_n)
        req_sys |=> (state == CAUSE_SYS));

    // R7: chip request wins over core
    a_r7_chip_over_core: assert property (@(posedge clk) disable iff (!rst_n)
        (req_chip && !req_sys) |=> (state == CAUSE_CHIP));

    // R7: lone core request loads core code
    a_r7_core: assert property (@(posedge clk) disable iff (!rst_n)
        (req_core && !req_chip && !req_sys) |=> (state == CAUSE_CORE));

    // R9: no request and no clear keeps the field
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_core && !req_chip && !req_sys && clr == 2'b00) |=> $stable(state));

endmodule

// File: rtl/dbg_status_reg.sv
module dbg_status_reg
    import dstat_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dbg_en,
    input  logic [NUM_EV-1:0]   ev_pulse,
    input  logic                rst_core_req,
    input  logic                rst_chip_req,
    input  logic                rst_sys_req,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wr_mask,
    output logic [WORD_W-1:0]   rd_data
);

    localparam int RSVD_LINES = line_of(LAST_USED);

    logic [NUM_STICKY-1:0] st_set;
    logic [NUM_STICKY-1:0] st_clr;
    logic [NUM_STICKY-1:0] st_q;
    logic [1:0]            cause_clr;
    logic                  any_reset;
    cause_e                cause;
    logic                  unused_mask_lines;

    assign any_reset = rst_core_req | rst_chip_req | rst_sys_req;

    // Slot 0: imprecise flag, raised by any event while debug is disabled
    assign st_set[0] = (|ev_pulse) & ~dbg_en;

    for (genvar e = 0; e < NUM_EV; e++) begin : g_ev_set
        assign st_set[e+1] = ev_pulse[e];
    end

    for (genvar k = 0; k < NUM_STICKY; k++) begin : g_clr
        assign st_clr[k] = wr_en & wr_mask[line_of(sticky_bit(k))];
    end

    assign cause_clr = {wr_en & wr_mask[line_of(CAUSE_HI)],
                        wr_en & wr_mask[line_of(CAUSE_LO)]};

    assign unused_mask_lines = ^wr_mask[RSVD_LINES-1:0];

    dstat_sticky #(
        .NB (NUM_STICKY)
    ) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .wipe  (any_reset),
        .set   (st_set),
        .clr   (st_clr),
        .q     (st_q)
    );

    dstat_cause_fsm u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_core (rst_core_req),
        .req_chip (rst_chip_req),
        .req_sys  (rst_sys_req),
        .clr      (cause_clr),
        .code     (cause)
    );

    // Read word assembly: combinational from stored state
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_STICKY; k++)
            rd_data[line_of(sticky_bit(k))] = st_q[k];
        rd_data[line_of(CAUSE_HI)] = cause[1];
        rd_data[line_of(CAUSE_LO)] = cause[0];
    end

    // R10: reserved lines read zero
    a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[RSVD_LINES-1:0] == '0);

    // R6: event with debug disabled raises the imprecise flag
    a_r6_imprecise: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ev_pulse) && !dbg_en && !any_reset) |=> rd_data[line_of(IMP_BIT)]);

    // R12: reset request wins over a clear of the cause field
    a_r12_load_over_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (any_reset && (|cause_clr)) |=> (rd_data[line_of(CAUSE_HI)] | rd_data[line_of(CAUSE_LO)]));

endmodule

// File: tb/sim_dbg_status_reg.sv
module sim_dbg_status_reg;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_en = 1'b1;
    logic [2:0]  ev_pulse = '0;
    logic        rst_core_req = 1'b0;
    logic        rst_chip_req = 1'b0;
    logic        rst_sys_req = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_mask = '0;
    logic [31:0] rd_data;

    int    checks = 0;
    int    errors = 0;
    item_t sb[$];
    logic [31:0] mdl = '0;

    always #2 clk = ~clk;

    dbg_status_reg u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .dbg_en       (dbg_en),
        .ev_pulse     (ev_pulse),
        .rst_core_req (rst_core_req),
        .rst_chip_req (rst_chip_req),
        .rst_sys_req  (rst_sys_req),
        .wr_en        (wr_en),
        .wr_mask      (wr_mask),
        .rd_data      (rd_data)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s rd_data=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus; rq = {sys, chip, core}
    task automatic cyc(input logic [2:0] ev, input logic en, input logic [2:0] rq,
                       input logic wr, input logic [31:0] m, input string tag);
        logic [31:0] nxt;
        @(negedge clk);
        ev_pulse = ev; dbg_en = en;
        rst_sys_req = rq[2]; rst_chip_req = rq[1]; rst_core_req = rq[0];
        wr_en = wr; wr_mask = m;
        #0;
        check(rd_data, mdl, "R11 pre-update read");
        if (|rq) begin
            nxt = '0;
            nxt[29:28] = rq[2] ? 2'b11 : (rq[1] ? 2'b10 : 2'b01);
        end else begin
            nxt = mdl;
            if (wr) nxt = nxt & ~m;
            if (ev[0]) nxt[30] = 1'b1;
            if (ev[1]) nxt[27] = 1'b1;
            if (ev[2]) nxt[26] = 1'b1;
            if ((|ev) && !en) nxt[31] = 1'b1;
        end
        nxt = nxt & 32'hFC00_0000;
        mdl = nxt;
        sb.push_back('{exp: nxt, tag: tag});
    endtask

    // Monitor: compares after each update edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check(rd_data, it.exp, it.tag);
            end
        end
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_data, 32'h0, "R1 reset value");

        cyc(3'b001, 1'b1, 3'b000, 1'b0, 32'h0,         "R5 unconditional to bit 1");
        cyc(3'b000, 1'b1, 3'b000, 1'b0, 32'h0,         "R2 sticky hold");
        cyc(3'b010, 1'b0, 3'b000, 1'b0, 32'h0,         "R6 imprecise with completion");
        cyc(3'b100, 1'b1, 3'b000, 1'b0, 32'h0,         "R5 branch to bit 5, R6 no new flag");
        cyc(3'b000, 1'b1, 3'b000, 1'b1, 32'h4000_0000, "R3 clear bit 1 only");
        cyc(3'b010, 1'b1, 3'b000, 1'b1, 32'h0800_0000, "R4 set beats clear");
        cyc(3'b000, 1'b1, 3'b000, 1'b1, 32'h03FF_FFFF, "R10 reserved mask no effect");
        cyc(3'b000, 1'b1, 3'b000, 1'b0, 32'h0,         "R2 sticky after writes");
        cyc(3'b000, 1'b1, 3'b001, 1'b0, 32'h0,         "R8 R7 core reset");
        cyc(3'b001, 1'b1, 3'b000, 1'b0, 32'h0,         "R9 event keeps cause");
        cyc(3'b100, 1'b0, 3'b010, 1'b0, 32'h0,         "R8 chip reset drops event");
        cyc(3'b000, 1'b1, 3'b101, 1'b0, 32'h0,         "R7 system over core");
        cyc(3'b000, 1'b1, 3'b011, 1'b0, 32'h0,         "R7 chip over core");
        cyc(3'b000, 1'b1, 3'b000, 1'b1, 32'h2000_0000, "R9 bitwise cause clear");
        cyc(3'b000, 1'b1, 3'b010, 1'b1, 32'h3000_0000, "R12 load beats clear");
        cyc(3'b011, 1'b0, 3'b000, 1'b1, 32'h0000_0001, "R3 R10 events with reserved mask");
        cyc(3'b000, 1'b1, 3'b000, 1'b1, 32'hFFFF_FFFF, "R3 R9 full clear");
        cyc(3'b000, 1'b1, 3'b000, 1'b0, 32'h0,         "R2 idle after clear");
        @(negedge clk);
        ev_pulse = '0; wr_en = 1'b0; wr_mask = '0;
        rst_core_req = 1'b0; rst_chip_req = 1'b0; rst_sys_req = 1'b0;
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule